// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is the register-and-pin half of one channel of a 16-bit general-purpose timer. It owns two general registers, named C and D, and one pin for each. A 4-bit mode code per register turns it into one of two things. As an output compare register it drives its pin to a chosen starting level and then sets, clears or inverts the pin each time the running count equals the register value. As an input capture register it copies the count into the register when its pin shows a chosen edge, or each time a neighbouring channel's counter steps.

The counter, its prescaler and the neighbouring channel live outside the block. They give it the count value, a count-enable strobe, a neighbour step strobe, and a flag that tells whether the neighbour is clocked at the undivided peripheral rate. Register D can take its capture pin from either pin. A buffer-pairing input for each register marks it as the buffer of another register, and that silences it. A one-cycle event flag for each register marks every match and every capture.

Top module: `tcc_channel`

## Requirements
- R1: After synchronous reset both mode codes are 0000, both general registers read 0, both pins are not driven (`pin_*_oe` = 0, `pin_*_out` = 0) and both event flags are 0.
- R2: Codes 0000 and 0100 make the register an output compare register with the pin not driven (oe = 0); a compare match still pulses its event flag.
- R3: Writing a code in 0001..0011 or 0101..0111 sets oe = 1 and drives the pin to code bit 2 (0 = low, 1 = high) right after the write edge, before any match.
- R4: In output compare mode a match occurs at a clock edge where `cnt_en` = 1 and `cnt_val` equals the register. At that edge the pin goes low (bits[1:0] = 01), high (10) or inverts (11). Without `cnt_en` there is no match.
- R5: Code 1000 captures on a rising pin edge, 1001 on a falling edge, and 101x on both edges, with oe = 0. Pins pass through two synchronizer flops and one edge flop, so the register takes the `cnt_val` present at the third rising clock edge after the pin changes.
- R6: Code 11xx captures `cnt_val` at the clock edge where `nb_count` = 1.
- R7: While `nb_clk_div1` = 1, a 11xx code produces no capture and no event.
- R8: While a register's buffer-pairing input is 1, that register produces no compare match and no capture: no event, and neither its register nor its pin changes.
- R9: Register D captures from pin D when `d_src_sel` = 0 and from pin C when `d_src_sel` = 1.
- R10: `reg_we[0]`/`reg_we[1]` load `reg_wdata` into register C/D, and the register values are visible on `gr_c`/`gr_d` one edge later.
- R11: Each event flag is a pulse of one clock per match or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current counter value |
| cnt_en | input | 1 | Counter advances this cycle; gates compare |
| nb_count | input | 1 | Neighbouring counter stepped up or down |
| nb_clk_div1 | input | 1 | Neighbour counts at the undivided clock |
| ctl_we | input | 2 | Mode code write strobes: bit0 C, bit1 D |
| ctl_wdata | input | 8 | Mode codes: [3:0] C, [7:4] D |
| reg_we | input | 2 | General register write strobes: bit0 C, bit1 D |
| reg_wdata | input | 16 | General register write data |
| buf_c | input | 1 | Register C is a buffer register |
| buf_d | input | 1 | Register D is a buffer register |
| d_src_sel | input | 1 | Capture pin for D: 0 pin D, 1 pin C |
| pin_c_in | input | 1 | Pin C input level |
| pin_d_in | input | 1 | Pin D input level |
| gr_c | output | 16 | Register C value |
| gr_d | output | 16 | Register D value |
| pin_c_out | output | 1 | Pin C output level |
| pin_c_oe | output | 1 | Pin C output enable |
| pin_d_out | output | 1 | Pin D output level |
| pin_d_oe | output | 1 | Pin D output enable |
| evt_c | output | 1 | Match/capture pulse for C |
| evt_d | output | 1 | Match/capture pulse for D |

## Verification
The hardest case to reach from the ports is the cross-routed capture. In that case register D must react to an edge on pin C and ignore one of the same polarity on its own pin. The stimulus first sets C to both-edge capture so pin C is busy. It then moves D's source select between two pin transitions while holding `cnt_val` at distinct values, so the value that lands in `gr_d` shows which pin fired. The neighbour-clock and buffer blocks are reached by raising `nb_count` and a compare hit while the blocking input is held. The bench then confirms that the register and pin stay put.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int TCC_CNT_W = 16;
    localparam int TCC_CODE_W = 4;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } match_act_e;

    typedef enum logic [1:0] {
        CAP_RISE  = 2'b00,
        CAP_FALL  = 2'b01,
        CAP_BOTH  = 2'b10,
        CAP_NEIGH = 2'b11
    } cap_src_e;

    typedef struct packed {
        logic       is_capture;
        logic       init_level;
        match_act_e act;
        cap_src_e   cap;
    } io_mode_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    function automatic io_mode_t decode_io(input logic [TCC_CODE_W-1:0] code);
        io_mode_t m;
        m.is_capture = code[3];
        m.init_level = code[2];
        m.act        = match_act_e'(code[1:0]);
        if (code[2])
            m.cap = CAP_NEIGH;
        else if (code[1])
            m.cap = CAP_BOTH;
        else if (code[0])
            m.cap = CAP_FALL;
        else
            m.cap = CAP_RISE;
        return m;
    endfunction

    function automatic logic drives_pin(input io_mode_t m);
        return !m.is_capture && (m.act != ACT_NONE);
    endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_in,
    output pin_edge_t edge_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    always_comb begin
        edge_o.rise = chain[LAST] & ~prev;
        edge_o.fall = ~chain[LAST] & prev;
    end
endmodule

// File: rtl/tcc_gr_slot.sv
module tcc_gr_slot
    import tcc_pkg::*;
#(
    parameter int CNT_W = TCC_CNT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctl_we,
    input  logic [TCC_CODE_W-1:0] ctl_wdata,
    input  logic                  reg_we,
    input  logic [CNT_W-1:0]      reg_wdata,
    input  logic [CNT_W-1:0]      cnt_val,
    input  logic                  cnt_en,
    input  pin_edge_t             pin_edge,
    input  logic                  nb_event_ok,
    input  logic                  buf_mode,
    output logic [CNT_W-1:0]      gr_q,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic                  evt,
    output logic [TCC_CODE_W-1:0] ctl_q
);
    io_mode_t mode_cur;
    io_mode_t mode_new;
    logic     cmp_hit;
    logic     cap_trig;
    logic     cap_hit;

    always_comb begin
        mode_cur = decode_io(ctl_q);
        mode_new = decode_io(ctl_wdata);
    end

    always_comb begin
        unique case (mode_cur.cap)
            CAP_RISE:  cap_trig = pin_edge.rise;
            CAP_FALL:  cap_trig = pin_edge.fall;
            CAP_BOTH:  cap_trig = pin_edge.rise | pin_edge.fall;
            CAP_NEIGH: cap_trig = nb_event_ok;
            default:   cap_trig = 1'b0;
        endcase
    end

    assign cmp_hit = !mode_cur.is_capture && !buf_mode && cnt_en && (cnt_val == gr_q);
    assign cap_hit = mode_cur.is_capture && !buf_mode && cap_trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
            if (drives_pin(mode_new)) begin
                pin_oe  <= 1'b1;
                pin_out <= mode_new.init_level;
            end else begin
                pin_oe  <= 1'b0;
                pin_out <= 1'b0;
            end
        end else if (cmp_hit) begin
            unique case (mode_cur.act)
                ACT_LOW:    pin_out <= 1'b0;
                ACT_HIGH:   pin_out <= 1'b1;
                ACT_TOGGLE: pin_out <= ~pin_out;
                default:    pin_out <= pin_out;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          gr_q <= '0;
        else if (reg_we)  gr_q <= reg_wdata;
        else if (cap_hit) gr_q <= cnt_val;
    end

    always_ff @(posedge clk) begin
        if (rst) evt <= 1'b0;
        else     evt <= cmp_hit | cap_hit;
    end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W       = TCC_CNT_W,
    parameter int SYNC_STAGES = 2,
    parameter bit D_CROSS_SRC = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cnt_val,
    input  logic             cnt_en,
    input  logic             nb_count,
    input  logic             nb_clk_div1,
    input  logic [1:0]       ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic [1:0]       reg_we,
    input  logic [15:0]      reg_wdata,
    input  logic             buf_c,
    input  logic             buf_d,
    input  logic             d_src_sel,
    input  logic             pin_c_in,
    input  logic             pin_d_in,
    output logic [15:0]      gr_c,
    output logic [15:0]      gr_d,
    output logic             pin_c_out,
    output logic             pin_c_oe,
    output logic             pin_d_out,
    output logic             pin_d_oe,
    output logic             evt_c,
    output logic             evt_d
);
    localparam int NSLOT = 2;

    pin_edge_t              pin_edge [NSLOT];
    pin_edge_t              slot_edge[NSLOT];
    logic [NSLOT-1:0]       pin_in_v;
    logic [NSLOT-1:0]       buf_v;
    logic [NSLOT-1:0]       out_v;
    logic [NSLOT-1:0]       oe_v;
    logic [NSLOT-1:0]       evt_v;
    logic [CNT_W-1:0]       gr_v  [NSLOT];
    logic [TCC_CODE_W-1:0]  ctl_v [NSLOT];
    logic [TCC_CODE_W-1:0]  ctl_c_q;
    logic [TCC_CODE_W-1:0]  ctl_d_q;
    logic                   nb_event_ok;

    assign pin_in_v    = {pin_d_in, pin_c_in};
    assign buf_v       = {buf_d, buf_c};
    assign nb_event_ok = nb_count & ~nb_clk_div1;

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_sync
            tcc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
                .clk    (clk),
                .rst    (rst),
                .pin_in (pin_in_v[s]),
                .edge_o (pin_edge[s])
            );
        end
    endgenerate

    assign slot_edge[0] = pin_edge[0];
    generate
        if (D_CROSS_SRC) begin : g_dsel
            assign slot_edge[1] = d_src_sel ? pin_edge[0] : pin_edge[1];
        end else begin : g_dfix
            assign slot_edge[1] = pin_edge[1];
        end
    endgenerate

    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            tcc_gr_slot #(.CNT_W(CNT_W)) u_slot (
                .clk         (clk),
                .rst         (rst),
                .ctl_we      (ctl_we[s]),
                .ctl_wdata   (ctl_wdata[s*TCC_CODE_W +: TCC_CODE_W]),
                .reg_we      (reg_we[s]),
                .reg_wdata   (reg_wdata[CNT_W-1:0]),
                .cnt_val     (cnt_val[CNT_W-1:0]),
                .cnt_en      (cnt_en),
                .pin_edge    (slot_edge[s]),
                .nb_event_ok (nb_event_ok),
                .buf_mode    (buf_v[s]),
                .gr_q        (gr_v[s]),
                .pin_out     (out_v[s]),
                .pin_oe      (oe_v[s]),
                .evt         (evt_v[s]),
                .ctl_q       (ctl_v[s])
            );
        end
    endgenerate

    assign gr_c      = 16'(gr_v[0]);
    assign gr_d      = 16'(gr_v[1]);
    assign pin_c_out = out_v[0];
    assign pin_d_out = out_v[1];
    assign pin_c_oe  = oe_v[0];
    assign pin_d_oe  = oe_v[1];
    assign evt_c     = evt_v[0];
    assign evt_d     = evt_v[1];
    assign ctl_c_q   = ctl_v[0];
    assign ctl_d_q   = ctl_v[1];
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  ctl_we,
    input logic [1:0]  reg_we,
    input logic        buf_c,
    input logic        buf_d,
    input logic        nb_clk_div1,
    input logic [3:0]  ctl_c_q,
    input logic [15:0] gr_c,
    input logic        pin_c_out,
    input logic        pin_c_oe,
    input logic        pin_d_oe,
    input logic        evt_c,
    input logic        evt_d
);
    // R8: a buffer register raises no event
    a_r8_buf_c_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(buf_c) |-> !evt_c);
    a_r8_buf_d_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(buf_d) |-> !evt_d);

    // R3: output enable only moves on a mode write
    a_r3_oe_c_on_write: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_we[0]) |-> $stable(pin_c_oe));
    a_r3_oe_d_on_write: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_we[1]) |-> $stable(pin_d_oe));

    // R4: without a mode write the pin only moves together with a match event
    a_r4_pin_c_on_event: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctl_we[0]) && (pin_c_out != $past(pin_c_out))) |-> evt_c);

    // R7: neighbour capture blocked at undivided neighbour clock
    a_r7_no_fast_capture: assert property (@(posedge clk) disable iff (rst)
        ($past(nb_clk_div1) && ($past(ctl_c_q[3:2]) == 2'b11) && !$past(reg_we[0]))
        |-> $stable(gr_c));
endmodule

bind tcc_channel tcc_channel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .reg_we      (reg_we),
    .buf_c       (buf_c),
    .buf_d       (buf_d),
    .nb_clk_div1 (nb_clk_div1),
    .ctl_c_q     (ctl_c_q),
    .gr_c        (gr_c),
    .pin_c_out   (pin_c_out),
    .pin_c_oe    (pin_c_oe),
    .pin_d_oe    (pin_d_oe),
    .evt_c       (evt_c),
    .evt_d       (evt_d)
);

// File: tb/sim_tcc_channel.sv
`timescale 1ns/1ps
module sim_tcc_channel;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_val;
    logic        cnt_en, nb_count, nb_clk_div1;
    logic [1:0]  ctl_we, reg_we;
    logic [7:0]  ctl_wdata;
    logic [15:0] reg_wdata;
    logic        buf_c, buf_d, d_src_sel, pin_c_in, pin_d_in;
    logic [15:0] gr_c, gr_d;
    logic        pin_c_out, pin_c_oe, pin_d_out, pin_d_oe, evt_c, evt_d;

    always #10 clk = ~clk;

    tcc_channel u0 (.*);

    typedef enum int {SEL_GRC, SEL_GRD, SEL_PC, SEL_PD, SEL_OEC, SEL_OED, SEL_EVC, SEL_EVD} sel_e;
    typedef struct {
        string       req;
        sel_e        sel;
        logic [15:0] exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [15:0] probe(sel_e s);
        case (s)
            SEL_GRC: return gr_c;
            SEL_GRD: return gr_d;
            SEL_PC:  return {15'd0, pin_c_out};
            SEL_PD:  return {15'd0, pin_d_out};
            SEL_OEC: return {15'd0, pin_c_oe};
            SEL_OED: return {15'd0, pin_d_oe};
            SEL_EVC: return {15'd0, evt_c};
            default: return {15'd0, evt_d};
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (q.size() > 0);
            begin
                item_t it;
                logic [15:0] act;
                it  = q.pop_front();
                act = probe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", it.req, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(string req, sel_e sel, logic [15:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic wr_ctl(int slot, logic [3:0] code);
        ctl_we = 2'b00;
        ctl_we[slot] = 1'b1;
        if (slot == 0) ctl_wdata[3:0] = code; else ctl_wdata[7:4] = code;
        step();
        ctl_we = 2'b00;
    endtask

    task automatic wr_reg(int slot, logic [15:0] v);
        reg_we = 2'b00;
        reg_we[slot] = 1'b1;
        reg_wdata = v;
        step();
        reg_we = 2'b00;
    endtask

    task automatic hit(logic [15:0] v);
        cnt_val = v; cnt_en = 1'b1;
        step();
        cnt_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        rst = 1; cnt_val = 0; cnt_en = 0; nb_count = 0; nb_clk_div1 = 0;
        ctl_we = 0; ctl_wdata = 0; reg_we = 0; reg_wdata = 0;
        buf_c = 0; buf_d = 0; d_src_sel = 0; pin_c_in = 0; pin_d_in = 0;
        step(3);
        rst = 0;
        step();
        // R1 reset state
        expect_out("R1", SEL_GRC, 0);
        expect_out("R1", SEL_OEC, 0);
        expect_out("R1", SEL_PD, 0);
        expect_out("R1", SEL_EVD, 0);

        // R10 register loads
        wr_reg(0, 16'h0010);
        expect_out("R10", SEL_GRC, 16'h0010);
        wr_reg(1, 16'h0020);
        expect_out("R10", SEL_GRD, 16'h0020);

        // R3 initial level on write
        wr_ctl(0, 4'b0101);
        expect_out("R3", SEL_OEC, 1);
        expect_out("R3", SEL_PC, 1);
        wr_ctl(1, 4'b0001);
        expect_out("R3", SEL_OED, 1);
        expect_out("R3", SEL_PD, 0);

        // R4 drive low at match, R11 single pulse
        hit(16'h0010);
        expect_out("R4", SEL_PC, 0);
        expect_out("R11", SEL_EVC, 1);
        step();
        expect_out("R11", SEL_EVC, 0);

        // R4 toggle, and no match without cnt_en
        wr_ctl(0, 4'b0011);
        expect_out("R3", SEL_PC, 0);
        cnt_val = 16'h0010;
        step();
        expect_out("R4", SEL_PC, 0);
        expect_out("R4", SEL_EVC, 0);
        hit(16'h0010);
        expect_out("R4", SEL_PC, 1);
        hit(16'h0010);
        expect_out("R4", SEL_PC, 0);
        hit(16'h0011);
        expect_out("R4", SEL_EVC, 0);

        // R4 drive high at match
        wr_ctl(0, 4'b0010);
        hit(16'h0010);
        expect_out("R4", SEL_PC, 1);

        // R4 D: high start, low at match
        wr_ctl(1, 4'b0101);
        hit(16'h0020);
        expect_out("R4", SEL_PD, 0);
        expect_out("R4", SEL_EVD, 1);

        // R2 output disabled still matches
        wr_ctl(0, 4'b0100);
        expect_out("R2", SEL_OEC, 0);
        hit(16'h0010);
        expect_out("R2", SEL_EVC, 1);
        expect_out("R2", SEL_OEC, 0);

        // R8 buffer register: no match
        wr_ctl(0, 4'b0011);
        buf_c = 1;
        hit(16'h0010);
        expect_out("R8", SEL_EVC, 0);
        expect_out("R8", SEL_PC, 0);
        buf_c = 0;

        // R5 rising-edge capture
        wr_ctl(0, 4'b1000);
        expect_out("R5", SEL_OEC, 0);
        cnt_val = 16'h1234; pin_c_in = 1;
        step(3);
        expect_out("R5", SEL_GRC, 16'h1234);
        expect_out("R5", SEL_EVC, 1);
        step();
        expect_out("R11", SEL_EVC, 0);
        cnt_val = 16'h2222; pin_c_in = 0;
        step(3);
        expect_out("R5", SEL_GRC, 16'h1234);
        // R5 falling edge
        wr_ctl(0, 4'b1001);
        cnt_val = 16'h2aaa; pin_c_in = 1;
        step(3);
        expect_out("R5", SEL_GRC, 16'h1234);
        cnt_val = 16'h3333; pin_c_in = 0;
        step(3);
        expect_out("R5", SEL_GRC, 16'h3333);
        // R5 both edges
        wr_ctl(0, 4'b1010);
        cnt_val = 16'h4444; pin_c_in = 1;
        step(3);
        expect_out("R5", SEL_GRC, 16'h4444);
        cnt_val = 16'h5555; pin_c_in = 0;
        step(3);
        expect_out("R5", SEL_GRC, 16'h5555);

        // R9 D capture routed from pin C
        wr_ctl(1, 4'b1000);
        d_src_sel = 1;
        cnt_val = 16'h6666; pin_c_in = 1;
        step(3);
        expect_out("R9", SEL_GRD, 16'h6666);
        pin_c_in = 0;
        step(3);
        d_src_sel = 0;
        cnt_val = 16'h7000; pin_c_in = 1;
        step(3);
        expect_out("R9", SEL_GRD, 16'h6666);
        cnt_val = 16'h7777; pin_d_in = 1;
        step(3);
        expect_out("R9", SEL_GRD, 16'h7777);

        // R6 neighbour count capture
        wr_ctl(0, 4'b1100);
        cnt_val = 16'h8888; nb_count = 1;
        step();
        nb_count = 0;
        expect_out("R6", SEL_GRC, 16'h8888);
        expect_out("R6", SEL_EVC, 1);

        // R7 undivided neighbour clock blocks capture
        nb_clk_div1 = 1;
        cnt_val = 16'h9999; nb_count = 1;
        step();
        nb_count = 0;
        expect_out("R7", SEL_GRC, 16'h8888);
        expect_out("R7", SEL_EVC, 0);
        nb_clk_div1 = 0;

        // R8 buffer register: no capture
        buf_c = 1;
        cnt_val = 16'haaaa; nb_count = 1;
        step();
        nb_count = 0;
        expect_out("R8", SEL_GRC, 16'h8888);
        expect_out("R8", SEL_EVC, 0);
        buf_c = 0;

        step(2);
        done = 1;
        finish_run();
    end
endmodule